// File: doc/BRIEF.md
# I3C Target Error Status Tracker

This block holds the sticky error and status flags that an I3C target reports to its controller and presents them together as one 32-bit read-only status word. The transfer engine and the buffer logic around it send single-cycle event pulses: errors seen during transfers, the reasons a request was NACKed, a controller change to the maximum read length, and the completion of a GETSTATUS CCC. The block also takes SCL rising-edge strobes, a resume command from the local application, and indications of free buffer space and write completion.

Each flag has its own set cause and its own clear cause. Most flags clear when the controller completes a GETSTATUS CCC. The target-busy flag clears only when the local application asserts resume. The buffer-not-available flag also clears in SDR mode once space is back and a write completes. The underflow flag does not appear at once: it shows up only after a set number of SCL rising edges have followed the read NACK that caused it. The current activity mode and the pending-interrupt value pass straight through into the status word. Reading the word has no side effects.

Top module: `i3c_tgt_err_status`

## Requirements
- R1: After a synchronous reset every field of `status_o` is 0. Bits 31:14 and bit 4 are always 0. The flags sit at these positions: frame error bit 13, buffer-not-available bit 12, data-not-ready bit 11, overflow bit 10, target-busy bit 9, underflow bit 8, protocol error bit 5.
- R2: A pulse on `ddr_frame_err_i` sets bit 13 at the next clock edge. A pulse on `getstatus_done_i` clears it.
- R3: If any bit of `bna_nack_i` is high (bit 0 means the RX buffer has too little space, bit 1 means the response buffer is full), bit 12 sets at the next edge. A pulse on `getstatus_done_i` clears it.
- R4: Bit 12 also clears when `sdr_mode_i`, `buf_space_i` and `wr_done_ok_i` are all high in the same cycle. If any one of the three is low, that cycle leaves bit 12 unchanged.
- R5: If any bit of `dnr_nack_i` is high (bit 0 means the command FIFO is empty, bit 1 means the TX threshold is not met, bit 2 means the response FIFO is full), bit 11 sets at the next edge. A pulse on `getstatus_done_i` clears it.
- R6: A pulse on `ovf_err_i` sets bit 10. A pulse on `getstatus_done_i` clears it.
- R7: A pulse on `parity_crc_err_i` sets bit 5. A pulse on `getstatus_done_i` clears it.
- R8: After a pulse on `rd_nack_empty_i`, bit 8 sets at the clock edge that samples the third later `scl_rise_i` strobe (UDF_SCL_DELAY = 3). A strobe in the same cycle as the NACK does not count. A new NACK restarts the count. A pulse on `getstatus_done_i` clears bit 8.
- R9: Bit 9 sets on `mrl_change_i` or on any error event: frame error, overflow, protocol error, or the delayed underflow set. It clears only on `resume_i`. A pulse on `getstatus_done_i` leaves it unchanged.
- R10: When a flag's set cause and clear cause arrive in the same cycle, the flag ends up set.
- R11: `status_o[7:6]` equals `act_mode_i` and `status_o[3:0]` equals `pend_int_i` in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ddr_frame_err_i | input | 1 | Frame error pulse from an HDR-DDR private write |
| bna_nack_i | input | 2 | Causes of a write NACK due to missing buffer space |
| dnr_nack_i | input | 3 | Causes of a NACK because data is not ready |
| ovf_err_i | input | 1 | Overflow pulse during a controller write |
| parity_crc_err_i | input | 1 | Parity or CRC error pulse during a write |
| rd_nack_empty_i | input | 1 | Read NACKed because the transmit buffer is empty |
| scl_rise_i | input | 1 | SCL rising-edge strobe |
| mrl_change_i | input | 1 | Controller changed the maximum read length |
| getstatus_done_i | input | 1 | GETSTATUS CCC completed |
| resume_i | input | 1 | Local application resume command |
| sdr_mode_i | input | 1 | Bus is in SDR mode |
| buf_space_i | input | 1 | Receive buffer space is available |
| wr_done_ok_i | input | 1 | A write transfer completed successfully |
| act_mode_i | input | 2 | Activity mode, passed through |
| pend_int_i | input | 4 | Pending interrupt value, passed through |
| status_o | output | 32 | Status word |

## Verification
The hardest case to reach is the delayed underflow set. It needs a read NACK followed by exactly the right number of SCL strobes, spread over cycles, while other events may arrive in between. The directed tests send a strobe in the same cycle as the NACK, insert idle cycles between strobes, and re-issue the NACK partway through a count. They check that the flag stays low until the third counted strobe and then rises together with target-busy. The conditional SDR clear is covered by vectors that hold only two of its three conditions high before applying all three.

// File: rtl/tgt_err_pkg.sv
package tgt_err_pkg;

    localparam int STAT_W    = 32;
    localparam int NUM_FLAGS = 7;

    localparam int FLG_FRM  = 0;
    localparam int FLG_BNA  = 1;
    localparam int FLG_DNR  = 2;
    localparam int FLG_OVF  = 3;
    localparam int FLG_BUSY = 4;
    localparam int FLG_UDF  = 5;
    localparam int FLG_PROT = 6;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef struct packed {
        logic [17:0] rsvd_hi;
        logic        frm;
        logic        bna;
        logic        dnr;
        logic        ovf;
        logic        busy;
        logic        udf;
        logic [1:0]  act;
        logic        prot;
        logic        rsvd4;
        logic [3:0]  pend;
    } status_word_t;

    function automatic status_word_t pack_status(flag_vec_t f, logic [1:0] act, logic [3:0] pend);
        status_word_t s;
        s.rsvd_hi = '0;
        s.frm     = f[FLG_FRM];
        s.bna     = f[FLG_BNA];
        s.dnr     = f[FLG_DNR];
        s.ovf     = f[FLG_OVF];
        s.busy    = f[FLG_BUSY];
        s.udf     = f[FLG_UDF];
        s.act     = act;
        s.prot    = f[FLG_PROT];
        s.rsvd4   = 1'b0;
        s.pend    = pend;
        return s;
    endfunction

endpackage

// File: rtl/err_flag_cell.sv
module err_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);                                     // R10

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);                        // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(flag_o));               // R10

endmodule

// File: rtl/udf_scl_delay.sv
module udf_scl_delay #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic scl_rise_i,
    output logic fire_o
);

    localparam int CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY);

    logic             armed;
    logic [CNT_W-1:0] edges;

    assign fire_o = armed && scl_rise_i && (edges == CNT_W'(DELAY - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            edges <= '0;
        end else if (start_i) begin
            armed <= 1'b1;
            edges <= '0;
        end else if (fire_o) begin
            armed <= 1'b0;
            edges <= '0;
        end else if (armed && scl_rise_i) begin
            edges <= edges + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        edges < CNT_W'(DELAY));                                // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!armed && !start_i) |=> !fire_o);                     // R8

    generate
        if (DELAY > 1) begin : g_not_early
            AST_NO_EARLY_FIRE: assert property (@(posedge clk) disable iff (rst)
                start_i |=> !fire_o);                          // R8
        end
    endgenerate

endmodule

// File: rtl/err_cause_map.sv
module err_cause_map
    import tgt_err_pkg::*;
#(
    parameter int NB = 2,
    parameter int ND = 3
) (
    input  logic          frm_i,
    input  logic [NB-1:0] bna_i,
    input  logic [ND-1:0] dnr_i,
    input  logic          ovf_i,
    input  logic          prot_i,
    input  logic          udf_fire_i,
    input  logic          mrl_i,
    input  logic          gs_i,
    input  logic          resume_i,
    input  logic          sdr_i,
    input  logic          space_i,
    input  logic          wr_done_i,
    output flag_vec_t     set_o,
    output flag_vec_t     clr_o
);

    logic any_err;
    assign any_err = frm_i | ovf_i | prot_i | udf_fire_i;

    always_comb begin
        set_o           = '0;
        set_o[FLG_FRM]  = frm_i;
        set_o[FLG_BNA]  = |bna_i;
        set_o[FLG_DNR]  = |dnr_i;
        set_o[FLG_OVF]  = ovf_i;
        set_o[FLG_PROT] = prot_i;
        set_o[FLG_UDF]  = udf_fire_i;
        set_o[FLG_BUSY] = mrl_i | any_err;

        clr_o           = '0;
        clr_o[FLG_FRM]  = gs_i;
        clr_o[FLG_BNA]  = gs_i | (sdr_i & space_i & wr_done_i);
        clr_o[FLG_DNR]  = gs_i;
        clr_o[FLG_OVF]  = gs_i;
        clr_o[FLG_PROT] = gs_i;
        clr_o[FLG_UDF]  = gs_i;
        clr_o[FLG_BUSY] = resume_i;
    end

endmodule

// File: rtl/i3c_tgt_err_status.sv
module i3c_tgt_err_status
    import tgt_err_pkg::*;
#(
    parameter int UDF_SCL_DELAY = 3,
    parameter int BNA_CAUSES    = 2,
    parameter int DNR_CAUSES    = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ddr_frame_err_i,
    input  logic [BNA_CAUSES-1:0] bna_nack_i,
    input  logic [DNR_CAUSES-1:0] dnr_nack_i,
    input  logic                  ovf_err_i,
    input  logic                  parity_crc_err_i,
    input  logic                  rd_nack_empty_i,
    input  logic                  scl_rise_i,
    input  logic                  mrl_change_i,
    input  logic                  getstatus_done_i,
    input  logic                  resume_i,
    input  logic                  sdr_mode_i,
    input  logic                  buf_space_i,
    input  logic                  wr_done_ok_i,
    input  logic [1:0]            act_mode_i,
    input  logic [3:0]            pend_int_i,
    output logic [STAT_W-1:0]     status_o
);

    logic      udf_fire;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t flags;

    udf_scl_delay #(.DELAY(UDF_SCL_DELAY)) u_udf_delay (
        .clk        (clk),
        .rst        (rst),
        .start_i    (rd_nack_empty_i),
        .scl_rise_i (scl_rise_i),
        .fire_o     (udf_fire)
    );

    err_cause_map #(.NB(BNA_CAUSES), .ND(DNR_CAUSES)) u_cause_map (
        .frm_i      (ddr_frame_err_i),
        .bna_i      (bna_nack_i),
        .dnr_i      (dnr_nack_i),
        .ovf_i      (ovf_err_i),
        .prot_i     (parity_crc_err_i),
        .udf_fire_i (udf_fire),
        .mrl_i      (mrl_change_i),
        .gs_i       (getstatus_done_i),
        .resume_i   (resume_i),
        .sdr_i      (sdr_mode_i),
        .space_i    (buf_space_i),
        .wr_done_i  (wr_done_ok_i),
        .set_o      (set_vec),
        .clr_o      (clr_vec)
    );

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
            err_flag_cell u_cell (
                .clk    (clk),
                .rst    (rst),
                .set_i  (set_vec[g]),
                .clr_i  (clr_vec[g]),
                .flag_o (flags[g])
            );
        end
    endgenerate

    assign status_o = pack_status(flags, act_mode_i, pend_int_i);

    AST_BUSY_ONLY_RESUME: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[9]) |-> $past(resume_i));                // R9

    AST_UDF_ON_SCL: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[8]) |-> $past(scl_rise_i));              // R8

    AST_BNA_CLEAR_SRC: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[12]) |->
            ($past(getstatus_done_i) ||
             ($past(sdr_mode_i) && $past(buf_space_i) && $past(wr_done_ok_i)))); // R4

    AST_FRM_CLEAR_SRC: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[13]) |-> $past(getstatus_done_i));       // R2

    AST_UDF_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[8]) |-> status_o[9]);                    // R9

endmodule

// File: tb/i3c_tgt_err_status_tb_top.sv
module i3c_tgt_err_status_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 24;

    logic        clk = 1'b0;
    logic        rst;
    logic        frm, ovf, prot, rdn, scl, mrl, gs, res, sdr, space, wrd;
    logic [1:0]  bna;
    logic [2:0]  dnr;
    logic [1:0]  act;
    logic [3:0]  pend;
    logic [31:0] status;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i3c_tgt_err_status dut_i (
        .clk              (clk),
        .rst              (rst),
        .ddr_frame_err_i  (frm),
        .bna_nack_i       (bna),
        .dnr_nack_i       (dnr),
        .ovf_err_i        (ovf),
        .parity_crc_err_i (prot),
        .rd_nack_empty_i  (rdn),
        .scl_rise_i       (scl),
        .mrl_change_i     (mrl),
        .getstatus_done_i (gs),
        .resume_i         (res),
        .sdr_mode_i       (sdr),
        .buf_space_i      (space),
        .wr_done_ok_i     (wrd),
        .act_mode_i       (act),
        .pend_int_i       (pend),
        .status_o         (status)
    );

    // inputs {frm,bna[1:0],dnr[2:0],ovf,prot,mrl,gs,res,sdr,space,wrd}
    // expect {frm13,bna12,dnr11,ovf10,busy9,udf8,prot5}
    localparam logic [20:0] VEC [NVEC] = '{
        {14'b0_00_000_0_0_0_0_0_0_0_0, 7'b0000000},
        {14'b1_00_000_0_0_0_0_0_0_0_0, 7'b1000100},
        {14'b0_00_000_0_0_0_1_0_0_0_0, 7'b0000100},
        {14'b0_00_000_0_0_0_0_1_0_0_0, 7'b0000000},
        {14'b0_01_000_0_0_0_0_0_0_0_0, 7'b0100000},
        {14'b0_00_000_0_0_0_0_0_0_1_1, 7'b0100000},
        {14'b0_00_000_0_0_0_0_0_1_0_1, 7'b0100000},
        {14'b0_00_000_0_0_0_0_0_1_1_1, 7'b0000000},
        {14'b0_10_000_0_0_0_0_0_0_0_0, 7'b0100000},
        {14'b0_00_000_0_0_0_1_0_0_0_0, 7'b0000000},
        {14'b0_00_001_0_0_0_0_0_0_0_0, 7'b0010000},
        {14'b0_00_010_0_0_0_1_0_0_0_0, 7'b0010000},
        {14'b0_00_000_0_0_0_1_0_0_0_0, 7'b0000000},
        {14'b0_00_100_0_0_0_0_0_0_0_0, 7'b0010000},
        {14'b0_00_000_1_0_0_0_0_0_0_0, 7'b0011100},
        {14'b0_00_000_0_1_0_1_0_0_0_0, 7'b0000101},
        {14'b0_00_000_0_0_1_0_1_0_0_0, 7'b0000101},
        {14'b0_00_000_0_0_0_0_1_0_0_0, 7'b0000001},
        {14'b0_00_000_0_0_0_1_0_0_0_0, 7'b0000000},
        {14'b0_00_000_0_0_1_0_0_0_0_0, 7'b0000100},
        {14'b0_00_000_0_0_0_1_0_0_0_0, 7'b0000100},
        {14'b0_00_000_0_0_0_0_1_0_0_0, 7'b0000000},
        {14'b0_01_000_0_0_0_0_0_1_1_1, 7'b0100000},
        {14'b0_00_000_0_0_0_1_0_0_0_0, 7'b0000000}
    };

    string vreq [NVEC] = '{
        "R1", "R2 R9", "R2", "R9", "R3", "R4", "R4", "R4", "R3", "R3",
        "R5", "R10 R5", "R5", "R5", "R6 R9", "R10 R7 R6", "R10 R9", "R9",
        "R7", "R9", "R9", "R9", "R10 R4", "R3"
    };

    function automatic logic [6:0] flags_of(logic [31:0] s);
        return {s[13], s[12], s[11], s[10], s[9], s[8], s[5]};
    endfunction

    task automatic check(string req, logic [31:0] actual, logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, actual, expected);
        end
    endtask

    task automatic idle_inputs();
        {frm, bna, dnr, ovf, prot, rdn, scl, mrl, gs, res, sdr, space, wrd} = '0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_scl(int n);
        for (int k = 0; k < n; k++) begin
            scl = 1'b1; step(); scl = 1'b0;
            step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        act = 2'b00; pend = 4'h0;
        rst = 1'b1;
        step(); step();
        check("R1 reset", status, 32'h0);
        rst = 1'b0;
        step();
        check("R1 after release", status, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            {frm, bna, dnr, ovf, prot, mrl, gs, res, sdr, space, wrd} = VEC[i][20:7];
            step();
            idle_inputs();
            check(vreq[i], {25'b0, flags_of(status)}, {25'b0, VEC[i][6:0]});
        end

        // R11 pass-through, same cycle, R1 reserved bits stay 0
        act = 2'b10; pend = 4'hB;
        #1;
        check("R11 passthrough", status, 32'h0000_008B);
        act = 2'b01; pend = 4'h4;
        #1;
        check("R11 R1 passthrough bit4", status, 32'h0000_0044);
        act = 2'b00; pend = 4'h0;
        #1;

        // R8 strobe in NACK cycle not counted
        rdn = 1'b1; scl = 1'b1; step(); idle_inputs();
        pulse_scl(2);
        check("R8 two strobes", status[9:8], 2'b00);
        step(); step();
        check("R8 idle cycles do not count", status[9:8], 2'b00);
        scl = 1'b1; step(); scl = 1'b0;
        check("R8 R9 third strobe", status[9:8], 2'b11);

        gs = 1'b1; step(); gs = 1'b0;
        check("R8 R9 getstatus clears udf only", status[9:8], 2'b10);
        res = 1'b1; step(); res = 1'b0;
        check("R9 resume", status[9:8], 2'b00);

        // R8 restart on new NACK
        rdn = 1'b1; step(); rdn = 1'b0;
        pulse_scl(2);
        rdn = 1'b1; step(); rdn = 1'b0;
        pulse_scl(2);
        check("R8 restart", status[8], 1'b0);
        pulse_scl(1);
        check("R8 after restart", status[8], 1'b1);

        // R1 mid-run reset clears flags
        frm = 1'b1; step(); frm = 1'b0;
        rst = 1'b1; step(); rst = 1'b0;
        check("R1 reset clears", status, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule